// File: doc/BRIEF.md
# Power-Managed Serial ADC Controller

This block is a host-side master for a serial analog-to-digital converter on a three-wire link. The three wires are an active-low chip select, a serial clock that the block generates, and a serial data line returned by the converter. The host pulses `start_i`. The controller then runs every frame needed to return one valid 10-bit sample and reports it on `result_o` with a one-cycle `result_valid_o` strobe.

The converter picks its power mode from the point in a frame at which chip select goes high:

- Raising it after at least ten falling edges of the serial clock leaves the converter powered.
- Raising it after two to nine falling edges aborts the frame and puts the converter into shutdown.
- A frame that begins while the converter is unpowered returns a result that cannot be used.

The controller tracks the converter's mode. Whenever that mode is unknown or shutdown, it runs a full-length dummy frame and discards its data. If `sleep_en_i` was high when the request was accepted, the controller follows the valid frame with a short frame that puts the converter back into shutdown. Every frame is separated from the next by a programmable quiet interval with chip select high.

Top module: `adc_pm_ctrl`

## Requirements
- R1: Out of reset and while idle, `cs_n_o` is 1, `sclk_o` is 1, `busy_o` is 0 and `result_valid_o` is 0. `sclk_o` only changes while `cs_n_o` was low in the previous cycle, and it is high whenever `cs_n_o` is high.
- R2: A normal frame drives `cs_n_o` low and toggles `sclk_o` every DIV_HALF system clocks, so its falling edges are 2*DIV_HALF cycles apart. It delivers exactly 16 falling edges. `cs_n_o` rises together with the 16th rising edge.
- R3: Frame bit k (k = 1..16) is taken from `sdata_i` at the rising edge that follows falling edge k. Bits 4 to 13 form `result_o`, with bit 4 as the MSB. Bits 1 to 3 and 14 to 16 have no effect on `result_o`.
- R4: The first request after reset runs a 16-edge dummy frame before the valid frame. The dummy frame's data is never reported.
- R5: Between any two frames, including between a dummy frame and the valid frame that follows it, `cs_n_o` stays high for at least QUIET_CLKS system clocks.
- R6: When sleep was requested, the valid frame and its quiet gap are followed by a frame of exactly 4 falling edges. This frame places the converter in shutdown.
- R7: A request made after a shutdown frame runs a dummy frame again before the valid frame.
- R8: A request made while the converter is known to be powered runs exactly one 16-edge frame, or two frames if sleep is requested.
- R9: `busy_o` goes high the cycle after a request is accepted. It stays high until the cycle of the one-cycle `result_valid_o` strobe, in which it is low. `start_i` pulses while busy start nothing.
- R10: `sleep_en_i` is sampled only in the cycle the request is accepted. Changes to it during the transaction do not change which frames run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, accepted when idle |
| sleep_en_i | input | 1 | Put the converter into shutdown after this sample |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| result_o | output | 10 | Last valid sample |
| result_valid_o | output | 1 | One-cycle strobe for `result_o` |
| busy_o | output | 1 | A transaction is in progress |

## Verification
The converter model returns a fixed garbage pattern from any frame that begins unpowered. A controller that skips the dummy frame after reset or after shutdown therefore reports that pattern instead of the expected sample. The model drives ones into the ignored leading and trailing bits, so an off-by-one in bit selection corrupts the result.

The model counts falling edges per frame and infers its own mode from the count at which chip select rises. A shutdown frame that is too long leaves it awake, and a full frame cut short puts it to sleep; in both cases the frame count of the next transaction is wrong. Flipping `sleep_en_i` mid-transaction and pulsing `start_i` while busy expose a controller that samples too late or accepts a second request; a second request shows up as an unexpected extra strobe.

// File: rtl/adc_pm_ctrl.sv
module adc_pm_ctrl #(
  parameter int DIV_HALF    = 2,
  parameter int QUIET_CLKS  = 16,
  parameter int FRAME_EDGES = 16,
  parameter int SHDN_EDGES  = 4,
  parameter int LEAD_BITS   = 3,
  parameter int DATA_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sleep_en_i,
  input  logic              sdata_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o,
  output logic              busy_o
);

  localparam int DIV_W     = $clog2(DIV_HALF) + 1;
  localparam int EDGE_W    = $clog2(FRAME_EDGES + 1);
  localparam int GAP_W     = $clog2(QUIET_CLKS + 1);
  localparam int FIRST_BIT = LEAD_BITS + 1;
  localparam int LAST_BIT  = LEAD_BITS + DATA_W;

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_GAP} state_t;
  typedef enum logic [1:0] {K_DUMMY, K_READ, K_SLEEP} kind_t;
  typedef enum logic [1:0] {M_UNKNOWN, M_AWAKE, M_ASLEEP} mode_t;

  state_t            state;
  kind_t             kind;
  mode_t             mode;
  logic              sleep_lat;
  logic [DIV_W-1:0]  div_cnt;
  logic [EDGE_W-1:0] edge_cnt;
  logic [GAP_W-1:0]  gap_cnt;
  logic [DATA_W-1:0] shreg;

  wire tick      = (state == S_FRAME) && (div_cnt == DIV_W'(DIV_HALF - 1));
  wire fall      = tick && sclk_o;
  wire rise      = tick && !sclk_o;
  wire [EDGE_W-1:0] frame_len = (kind == K_SLEEP) ? EDGE_W'(SHDN_EDGES) : EDGE_W'(FRAME_EDGES);
  wire last_rise = rise && (edge_cnt == frame_len);
  wire in_field  = (edge_cnt >= EDGE_W'(FIRST_BIT)) && (edge_cnt <= EDGE_W'(LAST_BIT));
  wire gap_end   = (state == S_GAP) && (gap_cnt == GAP_W'(QUIET_CLKS - 1));

  assign busy_o = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= S_IDLE;
      kind           <= K_DUMMY;
      mode           <= M_UNKNOWN;
      sleep_lat      <= 1'b0;
      cs_n_o         <= 1'b1;
      sclk_o         <= 1'b1;
      div_cnt        <= '0;
      edge_cnt       <= '0;
      gap_cnt        <= '0;
      shreg          <= '0;
      result_o       <= '0;
      result_valid_o <= 1'b0;
    end else begin
      result_valid_o <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_i) begin
            state     <= S_FRAME;
            kind      <= (mode == M_AWAKE) ? K_READ : K_DUMMY;
            sleep_lat <= sleep_en_i;
            cs_n_o    <= 1'b0;
            div_cnt   <= '0;
            edge_cnt  <= '0;
          end
        end
        S_FRAME: begin
          div_cnt <= tick ? '0 : div_cnt + 1'b1;
          if (tick) sclk_o <= !sclk_o;
          if (fall) edge_cnt <= edge_cnt + 1'b1;
          if (rise && kind == K_READ && in_field)
            shreg <= {shreg[DATA_W-2:0], sdata_i};
          if (last_rise) begin
            cs_n_o  <= 1'b1;
            state   <= S_GAP;
            gap_cnt <= '0;
            mode    <= (kind == K_SLEEP) ? M_ASLEEP : M_AWAKE;
          end
        end
        S_GAP: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_end) begin
            gap_cnt  <= '0;
            div_cnt  <= '0;
            edge_cnt <= '0;
            if (kind == K_DUMMY || (kind == K_READ && sleep_lat)) begin
              kind   <= (kind == K_DUMMY) ? K_READ : K_SLEEP;
              state  <= S_FRAME;
              cs_n_o <= 1'b0;
            end else begin
              state          <= S_IDLE;
              result_o       <= shreg;
              result_valid_o <= 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [GAP_W-1:0] hi_cnt;
  logic             armed;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      armed  <= 1'b0;
    end else begin
      armed <= armed | !cs_n_o;
      if (!cs_n_o) hi_cnt <= '0;
      else if (hi_cnt != GAP_W'(QUIET_CLKS)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  assert_sclk_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk_o) |-> !$past(cs_n_o));

  assert_quiet_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n_o) && armed) |-> (hi_cnt >= GAP_W'(QUIET_CLKS)));

  assert_strobe_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> (!busy_o && $past(busy_o)));

  assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |=> !result_valid_o);

endmodule

// File: tb/adc_pm_ctrl_tb.sv
module adc_pm_ctrl_tb;
  localparam int H  = 2;
  localparam int Q  = 16;
  localparam int DW = 10;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, sleep_en_i = 1'b0, sdata_i = 1'b0;
  logic cs_n_o, sclk_o, result_valid_o, busy_o;
  logic [DW-1:0] result_o;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  adc_pm_ctrl #(.DIV_HALF(H), .QUIET_CLKS(Q)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sleep_en_i(sleep_en_i),
    .sdata_i(sdata_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .result_o(result_o),
    .result_valid_o(result_valid_o), .busy_o(busy_o));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [DW-1:0] sample_of(input int i);
    int v;
    v = (i * 181 + 77) % 1024;
    return v[DW-1:0];
  endfunction

  // converter model
  bit adc_on = 1'b0;
  bit powered_at_start = 1'b0;
  int fe = 0, good_idx = 0, frames_in_txn = 0, last_fe = 0;
  logic [DW-1:0] cur_val = '0;

  always @(negedge cs_n_o) begin
    fe = 0;
    powered_at_start = adc_on;
    cur_val = adc_on ? sample_of(good_idx) : 10'h2AA;
  end

  always @(negedge sclk_o) begin
    if (cs_n_o === 1'b0) begin
      fe++;
      sdata_i = (fe >= 4 && fe <= 13) ? cur_val[13 - fe] : 1'b1;
    end
  end

  always @(posedge cs_n_o) begin
    if (rst_n) begin
      last_fe = fe;
      frames_in_txn++;
      if (fe >= 2 && fe < 10) adc_on = 1'b0;
      else if (fe >= 10) begin
        if (powered_at_start && fe >= 16) good_idx++;
        adc_on = 1'b1;
      end
    end
  end

  // scoreboard monitor
  logic [DW-1:0] expq[$];
  int strobes = 0;
  always @(negedge clk) begin
    if (rst_n && result_valid_o) begin
      strobes++;
      chk(busy_o == 1'b0, "R9", "busy low at strobe", busy_o, 0);
      if (expq.size() == 0) chk(1'b0, "R9", "unexpected strobe", result_o, -1);
      else begin
        logic [DW-1:0] e;
        e = expq.pop_front();
        chk(result_o == e, "R3", "result value", result_o, e);
      end
    end
  end

  // link timing monitor
  bit prev_s = 1'b1, armed = 1'b0;
  int cyc = 0, nfall = 0, cs_hi = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cs_n_o && !sclk_o) chk(1'b0, "R1", "sclk low while cs high", 0, 1);
      if (!cs_n_o && prev_s && !sclk_o) begin
        if (nfall > 0) chk(cyc == 2 * H, "R2", "sclk period", cyc, 2 * H);
        nfall++;
        cyc = 0;
      end
      if (cs_n_o) begin
        nfall = 0;
        cs_hi++;
      end else if (cs_hi > 0) begin
        if (armed) chk(cs_hi >= Q, "R5", "quiet gap cycles", cs_hi, Q);
        armed = 1'b1;
        cs_hi = 0;
      end
      prev_s = sclk_o;
    end
  end

  task automatic run_txn(input bit sleep, input bit poke, input string dreq);
    int exp_frames, exp_last, s0;
    exp_frames = (adc_on ? 1 : 2) + (sleep ? 1 : 0);
    exp_last = sleep ? 4 : 16;
    expq.push_back(sample_of(good_idx));
    s0 = strobes;
    frames_in_txn = 0;
    @(negedge clk);
    sleep_en_i = sleep;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
    sleep_en_i = !sleep;
    if (poke) begin
      repeat (30) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (strobes == s0) @(negedge clk);
    chk(frames_in_txn == exp_frames, dreq, "frames in transaction", frames_in_txn, exp_frames);
    chk(last_fe == exp_last, sleep ? "R6" : "R2", "falling edges in last frame", last_fe, exp_last);
    chk(adc_on == !sleep, "R10", "converter mode after transaction", adc_on, !sleep);
    repeat (Q + 80) @(negedge clk);
    chk(strobes == s0 + 1, "R9", "strobes per transaction", strobes - s0, 1);
    chk(busy_o == 1'b0 && cs_n_o == 1'b1, "R9", "idle after transaction", busy_o, 0);
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", "run timed out", 0, 1);
    finish_up();
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(cs_n_o == 1'b1 && sclk_o == 1'b1, "R1", "link idle in reset", {cs_n_o, sclk_o}, 3);
    chk(busy_o == 1'b0 && result_valid_o == 1'b0, "R1", "flags low in reset", {busy_o, result_valid_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n_o == 1'b1 && sclk_o == 1'b1 && busy_o == 1'b0, "R1", "idle after reset", {cs_n_o, sclk_o, busy_o}, 6);
    run_txn(1'b0, 1'b0, "R4");
    run_txn(1'b0, 1'b0, "R8");
    run_txn(1'b1, 1'b0, "R8");
    run_txn(1'b0, 1'b1, "R7");
    run_txn(1'b1, 1'b1, "R8");
    run_txn(1'b1, 1'b0, "R7");
    for (int i = 0; i < 4; i++) run_txn(1'b0, 1'b0, i == 0 ? "R7" : "R8");
    finish_up();
  end
endmodule